// File: doc/BRIEF.md
# DMA Burst Fragmenter with Bus Yield

This block sits at the front of a DMA engine and turns one transfer request into a stream of bus burst commands. A request carries an operation (memory copy or memory fill), a source address, a destination address and a 32-bit byte length. The block splits the length into bursts. Each burst is capped by a maximum byte count, and the read side and the write side each have their own cap. Burst commands leave on a valid/ready channel and carry an address, a byte count and a direction.

The bus must not be held for too long. Each side has its own limit on how many bursts it may issue back to back. When the next burst of a side would go past that side's limit, the block drops its bus request for one cycle and pulses a yield flag. It then clears both burst counters and requests the bus again. A one-cycle done pulse marks the end of each request.

The data path, data buffering and conversion to a real bus protocol belong to other blocks. The burst limits and transaction limits are captured when a request is accepted. A typical setting is 1024-byte bursts with 31 consecutive transactions per side.

Top module: `dma_burst_splitter`

## Requirements
- R1: The op encoding is 0 for copy and 1 for fill. A copy issues a read burst (cmd_write=0) and then a write burst (cmd_write=1) of the same byte count, and repeats this pair. A fill issues only write bursts.
- R2: Every read burst is at most the read byte limit, and every write burst is at most the write byte limit. A copy pair uses the smallest of the remaining length, the read limit and the write limit. A fill burst uses the smaller of the remaining length and the write limit. A limit of zero is treated as 1 byte.
- R3: When the length is not a multiple of the burst size, the last burst carries the remaining bytes. The bytes of all write bursts add up to the request length.
- R4: Read addresses start at the source address and write addresses start at the destination address. Each address advances by the byte count of the burst just issued on its side.
- R5: A side whose burst count since the last yield has reached its transaction limit issues no further burst until a yield. A yield is one cycle with bus_req low and bus_yield high, and it clears both counters. A yield happens only when bursts remain. A transaction limit of zero is treated as 1.
- R6: A request of zero length issues no burst. Its done pulse appears in the cycle right after acceptance.
- R7: done is high for one cycle, in the cycle right after the handshake of the final write burst. req_ready is high only while the block is idle.
- R8: While cmd_valid is high and cmd_ready is low, the command address, byte count and direction stay unchanged.
- R9: Out of reset, req_ready=1 and cmd_valid, bus_req, bus_yield and done are all 0.
- R10: The byte limits and transaction limits are sampled when the request is accepted. Changing them during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_op | input | 1 | 0 = copy, 1 = fill |
| req_src | input | AW | Source start address |
| req_dst | input | AW | Destination start address |
| req_len | input | LW | Byte length |
| cfg_rd_bytes | input | BW | Read burst byte limit |
| cfg_wr_bytes | input | BW | Write burst byte limit |
| cfg_rd_txns | input | TW | Read bursts allowed back to back |
| cfg_wr_txns | input | TW | Write bursts allowed back to back |
| cmd_valid | output | 1 | Burst command valid |
| cmd_ready | input | 1 | Burst command accepted |
| cmd_write | output | 1 | 1 = write burst, 0 = read burst |
| cmd_addr | output | AW | Burst start address |
| cmd_bytes | output | BW | Burst byte count |
| bus_req | output | 1 | Bus wanted |
| bus_yield | output | 1 | One-cycle bus release |
| done | output | 1 | Request complete pulse |

## Verification
The bench builds the expected sequence of reads, writes and yields from the rules above and compares it, entry by entry, against what the block emits. It covers the following corner cases:

- **Uneven length.** A length that is not a multiple of the burst size must end on a short burst. A design that rounds up would overrun the end address.
- **Unequal read and write limits.** A design that sized copy pairs by only one side's limit would issue oversized bursts on the other side.
- **Unequal transaction limits.** Different per-side limits must yield at the exact burst where the earlier side runs out. Backpressure is applied at the same time, to catch commands that change while stalled.
- **Zero settings.** A zero-length request must produce no bursts, and zero limits must not hang the block.
- **Limits changed mid-transfer.** This exposes a design that reads the limits live rather than capturing them at acceptance.

// File: rtl/dbs_pkg.sv
// Shared types for the DMA burst fragmenter.
// Assumes: op encoding fixed as copy=0, fill=1.
package dbs_pkg;
    typedef enum logic {
        OP_COPY = 1'b0,
        OP_FILL = 1'b1
    } dbs_op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD    = 3'd1,
        ST_WR    = 3'd2,
        ST_YIELD = 3'd3,
        ST_DONE  = 3'd4
    } dbs_state_e;
endpackage

// File: rtl/dbs_chunk_calc.sv
// Burst size selection: smallest of remaining length, primary limit and
// (optionally) secondary limit. A zero limit counts as one byte.
// Assumes: LW > BW.
module dbs_chunk_calc #(
    parameter int LW = 32,
    parameter int BW = 16
) (
    input  logic [LW-1:0] rem,
    input  logic [BW-1:0] lim_a,
    input  logic [BW-1:0] lim_b,
    input  logic          use_b,
    output logic [BW-1:0] chunk
);
    logic [BW-1:0] eff_a, eff_b, cap;

    // Clamp zero limits up to one byte and pick the tighter cap.
    always_comb begin
        eff_a = (lim_a == '0) ? BW'(1) : lim_a;
        eff_b = (lim_b == '0) ? BW'(1) : lim_b;
        cap   = (use_b && (eff_b < eff_a)) ? eff_b : eff_a;
        chunk = (rem < LW'(cap)) ? rem[BW-1:0] : cap;
    end
endmodule

// File: rtl/dbs_txn_counter.sv
// Consecutive-burst counter for one bus side. full_after reports whether
// the count, including a burst handshaken this cycle, has reached the limit.
// Assumes: the count is cleared before it can pass the limit.
module dbs_txn_counter #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [TW-1:0] lim,
    output logic          full_after
);
    logic [TW-1:0] cnt_q;
    logic [TW:0]   cnt_next;
    logic [TW-1:0] eff_lim;

    // Next count and limit comparison (zero limit counts as one).
    always_comb begin
        eff_lim    = (lim == '0) ? TW'(1) : lim;
        cnt_next   = {1'b0, cnt_q} + {{TW{1'b0}}, inc};
        full_after = cnt_next >= {1'b0, eff_lim};
    end

    // Count handshaken bursts; clear on yield or idle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (inc)      cnt_q <= cnt_next[TW-1:0];
    end
endmodule

// File: rtl/dma_burst_splitter.sv
// DMA burst fragmenter: splits a copy or fill request into read/write
// bursts capped per side, and forces a one-cycle bus release after each
// side's back-to-back burst limit.
// Assumes: AW > BW, LW > BW; limits captured at request acceptance.
module dma_burst_splitter
    import dbs_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 32,
    parameter int BW = 16,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_op,
    input  logic [AW-1:0] req_src,
    input  logic [AW-1:0] req_dst,
    input  logic [LW-1:0] req_len,
    input  logic [BW-1:0] cfg_rd_bytes,
    input  logic [BW-1:0] cfg_wr_bytes,
    input  logic [TW-1:0] cfg_rd_txns,
    input  logic [TW-1:0] cfg_wr_txns,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic          cmd_write,
    output logic [AW-1:0] cmd_addr,
    output logic [BW-1:0] cmd_bytes,
    output logic          bus_req,
    output logic          bus_yield,
    output logic          done
);
    dbs_state_e    state_q, ret_q;
    dbs_op_e       op_q;
    logic [AW-1:0] src_q, dst_q;
    logic [LW-1:0] rem_q, rem_after;
    logic [BW-1:0] pair_q, chunk;
    logic [BW-1:0] rd_b_q, wr_b_q;
    logic [TW-1:0] rd_t_q, wr_t_q;
    logic          hs, rd_hs, wr_hs, cnt_clr, rd_full, wr_full, fill_q;

    assign fill_q = (op_q == OP_FILL);

    // Burst size for the current position.
    dbs_chunk_calc #(.LW(LW), .BW(BW)) u_chunk (
        .rem   (rem_q),
        .lim_a (wr_b_q),
        .lim_b (rd_b_q),
        .use_b (!fill_q),
        .chunk (chunk)
    );

    assign hs      = cmd_valid && cmd_ready;
    assign rd_hs   = hs && (state_q == ST_RD);
    assign wr_hs   = hs && (state_q == ST_WR);
    assign cnt_clr = (state_q == ST_YIELD) || (state_q == ST_IDLE);

    dbs_txn_counter #(.TW(TW)) u_rd_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (cnt_clr),
        .inc        (rd_hs),
        .lim        (rd_t_q),
        .full_after (rd_full)
    );

    dbs_txn_counter #(.TW(TW)) u_wr_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (cnt_clr),
        .inc        (wr_hs),
        .lim        (wr_t_q),
        .full_after (wr_full)
    );

    // Output decode from the current state.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        cmd_valid = (state_q == ST_RD) || (state_q == ST_WR);
        bus_req   = cmd_valid;
        bus_yield = (state_q == ST_YIELD);
        done      = (state_q == ST_DONE);
        cmd_write = (state_q == ST_WR);
        cmd_addr  = (state_q == ST_WR) ? dst_q : src_q;
        cmd_bytes = (state_q == ST_WR && !fill_q) ? pair_q : chunk;
        rem_after = rem_q - {{(LW-BW){1'b0}}, cmd_bytes};
    end

    // Sequencing: accept, alternate/repeat bursts, yield, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ret_q   <= ST_IDLE;
            op_q    <= OP_COPY;
            src_q   <= '0;
            dst_q   <= '0;
            rem_q   <= '0;
            pair_q  <= '0;
            rd_b_q  <= '0;
            wr_b_q  <= '0;
            rd_t_q  <= '0;
            wr_t_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    op_q   <= dbs_op_e'(req_op);
                    src_q  <= req_src;
                    dst_q  <= req_dst;
                    rem_q  <= req_len;
                    rd_b_q <= cfg_rd_bytes;
                    wr_b_q <= cfg_wr_bytes;
                    rd_t_q <= cfg_rd_txns;
                    wr_t_q <= cfg_wr_txns;
                    if (req_len == '0)            state_q <= ST_DONE;
                    else if (req_op == OP_FILL)   state_q <= ST_WR;
                    else                          state_q <= ST_RD;
                end
                ST_RD: if (hs) begin
                    src_q  <= src_q + {{(AW-BW){1'b0}}, cmd_bytes};
                    pair_q <= cmd_bytes;
                    if (wr_full) begin
                        state_q <= ST_YIELD;
                        ret_q   <= ST_WR;
                    end else begin
                        state_q <= ST_WR;
                    end
                end
                ST_WR: if (hs) begin
                    dst_q <= dst_q + {{(AW-BW){1'b0}}, cmd_bytes};
                    rem_q <= rem_after;
                    if (rem_after == '0) begin
                        state_q <= ST_DONE;
                    end else if (fill_q) begin
                        state_q <= wr_full ? ST_YIELD : ST_WR;
                        ret_q   <= ST_WR;
                    end else begin
                        state_q <= rd_full ? ST_YIELD : ST_RD;
                        ret_q   <= ST_RD;
                    end
                end
                ST_YIELD: state_q <= ret_q;
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dbs_checker.sv
// Protocol checker for dma_burst_splitter, attached by bind.
// Assumes: byte limits given are those captured inside the block.
module dbs_checker #(
    parameter int AW = 32,
    parameter int BW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic          cmd_write,
    input logic [AW-1:0] cmd_addr,
    input logic [BW-1:0] cmd_bytes,
    input logic          bus_req,
    input logic          bus_yield,
    input logic          done,
    input logic          req_ready,
    input logic          fill_q,
    input logic [BW-1:0] rd_b_q,
    input logic [BW-1:0] wr_b_q
);
    logic [BW-1:0] rd_eff, wr_eff;
    assign rd_eff = (rd_b_q == '0) ? BW'(1) : rd_b_q;
    assign wr_eff = (wr_b_q == '0) ? BW'(1) : wr_b_q;

    p_fill_writes_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && fill_q |-> cmd_write);

    p_read_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_write |-> (cmd_bytes <= rd_eff) && (cmd_bytes != '0));

    p_write_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_write |-> (cmd_bytes <= wr_eff) && (cmd_bytes != '0));

    p_yield_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_yield |-> !bus_req && !cmd_valid);

    p_yield_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_yield |=> !bus_yield);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !req_ready && bus_req);

    p_hold_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr));

    p_hold_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> $stable(cmd_bytes) && $stable(cmd_write));
endmodule

bind dma_burst_splitter dbs_checker #(.AW(AW), .BW(BW)) u_dbs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_write (cmd_write),
    .cmd_addr  (cmd_addr),
    .cmd_bytes (cmd_bytes),
    .bus_req   (bus_req),
    .bus_yield (bus_yield),
    .done      (done),
    .req_ready (req_ready),
    .fill_q    (fill_q),
    .rd_b_q    (rd_b_q),
    .wr_b_q    (wr_b_q)
);

// File: tb/tb_dma_burst_splitter.sv
module tb_dma_burst_splitter;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32, LW = 32, BW = 16, TW = 8;
    localparam int MAXEV = 512;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_op = 0;
    logic req_ready;
    logic [AW-1:0] req_src = 0, req_dst = 0;
    logic [LW-1:0] req_len = 0;
    logic [BW-1:0] cfg_rd_bytes = 0, cfg_wr_bytes = 0;
    logic [TW-1:0] cfg_rd_txns = 0, cfg_wr_txns = 0;
    logic cmd_valid, cmd_ready = 0, cmd_write;
    logic [AW-1:0] cmd_addr;
    logic [BW-1:0] cmd_bytes;
    logic bus_req, bus_yield, done;

    int checks = 0, errors = 0;
    int cyc = 0;
    int ready_mode = 0;
    bit mon_on = 0;

    // event kinds: 0 read, 1 write, 2 yield
    int exp_k[MAXEV]; longint exp_a[MAXEV]; int exp_b[MAXEV]; int exp_n;
    int act_k[MAXEV]; longint act_a[MAXEV]; int act_b[MAXEV]; int act_n;
    int done_cnt, done_cyc, last_hs_cyc;

    dma_burst_splitter #(.AW(AW), .LW(LW), .BW(BW), .TW(TW)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: set ready for the coming edge, then record what will happen on it.
    initial begin
        bit stalled = 0;
        logic [AW-1:0] s_addr; logic [BW-1:0] s_bytes; logic s_wr;
        forever begin
            @(negedge clk);
            if (!mon_on) begin
                stalled = 0;
                continue;
            end
            if (stalled) begin // R8: held command unchanged
                chk(cmd_valid && cmd_addr == s_addr && cmd_bytes == s_bytes && cmd_write == s_wr,
                    "R8 held command", longint'(cmd_addr), longint'(s_addr));
            end
            cmd_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
            if (cmd_valid && !req_ready && act_n < MAXEV) begin
                if (cmd_ready) begin
                    act_k[act_n] = cmd_write ? 1 : 0;
                    act_a[act_n] = cmd_addr;
                    act_b[act_n] = cmd_bytes;
                    act_n++;
                    last_hs_cyc = cyc;
                end
            end
            if (bus_yield && act_n < MAXEV) begin
                chk(!bus_req, "R5 bus_req low in yield", bus_req, 0);
                act_k[act_n] = 2; act_a[act_n] = 0; act_b[act_n] = 0; act_n++;
            end
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
            end
            stalled = cmd_valid && !cmd_ready;
            s_addr = cmd_addr; s_bytes = cmd_bytes; s_wr = cmd_write;
        end
    end

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic push(input int k, input longint a, input int b);
        exp_k[exp_n] = k; exp_a[exp_n] = a; exp_b[exp_n] = b; exp_n++;
    endtask

    // Independent expected-sequence model from the requirements.
    task automatic model(input bit fill, input longint src, input longint dst, input longint len,
                         input int rb, input int wb, input int rt, input int wt);
        longint rem = len, s = src, d = dst;
        int rc = 0, wc = 0, c;
        exp_n = 0;
        while (rem > 0) begin
            if (!fill) begin
                if (rc == eff(rt)) begin push(2, 0, 0); rc = 0; wc = 0; end
                c = eff(rb) < eff(wb) ? eff(rb) : eff(wb);
                if (rem < c) c = int'(rem);
                push(0, s, c); rc++; s += c;
                if (wc == eff(wt)) begin push(2, 0, 0); rc = 0; wc = 0; end
            end else begin
                if (wc == eff(wt)) begin push(2, 0, 0); rc = 0; wc = 0; end
                c = eff(wb);
                if (rem < c) c = int'(rem);
            end
            push(1, d, c); wc++; d += c; rem -= c;
        end
    endtask

    task automatic run(input string tag, input bit fill, input longint src, input longint dst,
                       input longint len, input int rb, input int wb, input int rt, input int wt,
                       input int rmode, input bit scramble);
        int acc_cyc, t;
        longint wsum;
        model(fill, src, dst, len, rb, wb, rt, wt);
        @(negedge clk);
        ready_mode = rmode;
        act_n = 0; done_cnt = 0; done_cyc = -1; last_hs_cyc = -1;
        req_op = fill; req_src = AW'(src); req_dst = AW'(dst); req_len = LW'(len);
        cfg_rd_bytes = BW'(rb); cfg_wr_bytes = BW'(wb);
        cfg_rd_txns = TW'(rt); cfg_wr_txns = TW'(wt);
        chk(req_ready, {tag, " R7 ready when idle"}, req_ready, 1);
        req_valid = 1; acc_cyc = cyc; mon_on = 1;
        @(negedge clk);
        req_valid = 0;
        if (scramble) begin // R10: new limits must not affect this transfer
            cfg_rd_bytes = 3; cfg_wr_bytes = 5; cfg_rd_txns = 1; cfg_wr_txns = 1;
        end
        if (len > 0) chk(!req_ready, {tag, " R7 ready low while busy"}, req_ready, 0);
        t = 0;
        while (done_cnt == 0 && t < 20000) begin @(negedge clk); t++; end
        chk(done_cnt != 0, {tag, " watchdog: done seen"}, done_cnt, 1);
        repeat (3) @(negedge clk);
        mon_on = 0;
        chk(done_cnt == 1, {tag, " R7 single done"}, done_cnt, 1);
        if (len == 0) chk(done_cyc == acc_cyc + 1, {tag, " R6 done timing"}, done_cyc, acc_cyc + 1);
        else chk(done_cyc == last_hs_cyc + 1, {tag, " R7 done timing"}, done_cyc, last_hs_cyc + 1);
        chk(act_n == exp_n, {tag, " R1/R5 event count"}, act_n, exp_n);
        wsum = 0;
        for (int i = 0; i < act_n && i < exp_n; i++) begin
            chk(act_k[i] == exp_k[i], {tag, " R1 R5 event kind"}, act_k[i], exp_k[i]);
            chk(act_a[i] == exp_a[i], {tag, " R4 address"}, act_a[i], exp_a[i]);
            chk(act_b[i] == exp_b[i], {tag, " R2 R3 burst bytes"}, act_b[i], exp_b[i]);
            if (act_k[i] == 1) wsum += act_b[i];
        end
        chk(wsum == len, {tag, " R3 write total"}, wsum, len);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(req_ready && !cmd_valid && !bus_req && !bus_yield && !done,
            "R9 reset outputs", {req_ready, cmd_valid, bus_req, bus_yield, done}, 5'b10000);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && !cmd_valid && !done, "R9 idle after reset", req_ready, 1);

        run("copy_uneven",  0, 'h1000, 'h8000, 100, 32, 64, 8, 8, 0, 0);   // R1 R2 R3 R4
        run("fill_yield",   1, 0, 'h2000, 1000, 0, 256, 0, 2, 0, 0);       // R1 R5
        run("copy_txn_bp",  0, 'h40, 'h900, 200, 16, 16, 2, 3, 1, 0);      // R5 R8
        run("copy_wr_tight",0, 'h10, 'h20, 70, 64, 24, 4, 4, 1, 0);        // R2
        run("zero_len",     0, 'h10, 'h20, 0, 16, 16, 4, 4, 0, 0);         // R6
        run("zero_limits",  1, 0, 'h300, 3, 0, 0, 0, 0, 0, 0);             // R2 R5
        run("cfg_change",   1, 0, 'h500, 64, 16, 16, 10, 10, 1, 1);        // R10
        run("typical",      0, 'h100000, 'h200000, 70000, 1024, 1024, 31, 31, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule